// File: doc/BRIEF.md
# Dual-Source Tick Prescaler

This block turns one of two clock sources into a single-cycle tick enable for a timer half. The first source is the system clock itself, with a pulse on every cycle. The second source is a 32768 Hz real-time pulse that has already been synchronized into the system clock domain. A per-timer select picks the source. A 3-bit code then picks one of eight power-of-two ratios, and each source has its own table of ratios.

Each source has a shared group enable bit. When that bit is clear, the source's divider chain freezes and no tick comes from that source. Each chain is free-running and is never cleared by a code change. A new code therefore takes effect at the next count that matches the new ratio. The tick is registered, so `tick_o` rises one system clock cycle after the qualifying source pulse.

Top module: `dual_osc_prescaler`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0, and both divider chains restart from zero when reset is released.
- R2: With `osc_sel_i`=0 (system clock) and `grp_en_i[0]`=1, codes 0..7 of `scale_i` give one tick every 2, 8, 32, 64, 128, 256, 1024 and 4096 system cycles. The first tick comes that many cycles after reset is released.
- R3: With `osc_sel_i`=1 (real-time pulse) and `grp_en_i[1]`=1, codes 0..7 give one tick every 1, 2, 4, 8, 16, 32, 64 and 128 pulses of `rtc_pulse_i`. Each tick appears in the cycle after the pulse that completes the count, and never in the cycle after a cycle with no pulse.
- R4: When `grp_en_i[0]`=0, no tick is produced from the system clock source. That chain holds its count and resumes from the same count when the bit is set again.
- R5: When `grp_en_i[1]`=0, no tick is produced from the real-time source. That chain holds its count and resumes from the same count when the bit is set again.
- R6: The enable bit of the source that is not selected has no effect on the selected source's ticks.
- R7: A change of `scale_i` or `osc_sel_i` needs no reset. The chains keep counting, and the next tick follows the new ratio applied to the running count.
- R8: `tick_o` is high for exactly one system clock cycle per tick. This assumes `rtc_pulse_i` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_pulse_i | input | 1 | Synchronized 32768 Hz single-cycle pulse |
| osc_sel_i | input | 1 | Source select: 0 system clock, 1 real-time pulse |
| scale_i | input | 3 | Ratio code for the selected source |
| grp_en_i | input | 2 | Group enables: bit 0 system clock source, bit 1 real-time source |
| tick_o | output | 1 | Single-cycle tick enable |

## Verification
On every cycle, the assertions check four things. A disabled source never yields a tick. A tick from the real-time source always follows a pulse. A tick never lasts two cycles. The output stays low in reset. The exact ratio for each code, the held phase across a disable and re-enable, and the way the next tick continues the running count after a code or source change can only be shown by the bench. Its cycle-accurate reference model predicts every output cycle across scenarios that walk all sixteen ratios and toggle enables mid-count.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned SHIFT_W  = 4;
  localparam int unsigned NUM_OSC  = 2;
  localparam int unsigned MAX_LOG2 = 12;

  typedef enum logic {OSC_SYS = 1'b0, OSC_RTC = 1'b1} osc_e;

  // log2 of the divide ratio for each source and code
  function automatic logic [SHIFT_W-1:0] div_log2(input int unsigned osc,
                                                  input logic [CODE_W-1:0] code);
    logic [SHIFT_W-1:0] r;
    if (osc == 0) begin
      case (code)
        3'd0: r = 4'd1;
        3'd1: r = 4'd3;
        3'd2: r = 4'd5;
        3'd3: r = 4'd6;
        3'd4: r = 4'd7;
        3'd5: r = 4'd8;
        3'd6: r = 4'd10;
        default: r = 4'd12;
      endcase
    end else begin
      r = {1'b0, code};
    end
    return r;
  endfunction
endpackage

// File: rtl/ps_div_chain.sv
module ps_div_chain #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_pulse_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (en_i && src_pulse_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/ps_tap_match.sv
module ps_tap_match #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               src_pulse_i,
  input  logic               en_i,
  output logic               hit_o
);
  logic [CNT_W-1:0] mask;
  always_comb begin
    mask  = (CNT_W'(1) << shift_i) - CNT_W'(1);
    // final pulse of a full period: low bits about to wrap
    hit_o = en_i & src_pulse_i & ((cnt_i & mask) == mask);
  end
endmodule

// File: rtl/dual_osc_prescaler.sv
module dual_osc_prescaler
  import prescale_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_pulse_i,
  input  logic              osc_sel_i,
  input  logic [CODE_W-1:0] scale_i,
  input  logic [1:0]        grp_en_i,
  output logic              tick_o
);
  localparam int unsigned CNT_W = MAX_LOG2;

  logic [NUM_OSC-1:0] src_pulse;
  logic [NUM_OSC-1:0] hit;
  osc_e               sel;

  assign src_pulse = {rtc_pulse_i, 1'b1};
  assign sel       = osc_e'(osc_sel_i);

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    logic [CNT_W-1:0]   cnt;
    logic [SHIFT_W-1:0] shift;

    assign shift = div_log2(g, scale_i);

    ps_div_chain #(.CNT_W(CNT_W)) u_chain (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_pulse_i (src_pulse[g]),
      .en_i        (grp_en_i[g]),
      .cnt_o       (cnt)
    );

    ps_tap_match #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_tap (
      .cnt_i       (cnt),
      .shift_i     (shift),
      .src_pulse_i (src_pulse[g]),
      .en_i        (grp_en_i[g]),
      .hit_o       (hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= (sel == OSC_RTC) ? hit[1] : hit[0];
  end
endmodule

// File: rtl/dual_osc_prescaler_chk.sv
module dual_osc_prescaler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rtc_pulse_i,
  input logic       osc_sel_i,
  input logic [1:0] grp_en_i,
  input logic       tick_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r1: assert (!tick_o);
  end

  p_rtc_follows_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_sel_i && !rtc_pulse_i) |=> !tick_o);

  p_sys_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_sel_i && !grp_en_i[0]) |=> !tick_o);

  p_rtc_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_sel_i && !grp_en_i[1]) |=> !tick_o);

  p_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !(osc_sel_i && rtc_pulse_i)) |=> !tick_o);
endmodule

bind dual_osc_prescaler dual_osc_prescaler_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rtc_pulse_i (rtc_pulse_i),
  .osc_sel_i   (osc_sel_i),
  .grp_en_i    (grp_en_i),
  .tick_o      (tick_o)
);

// File: tb/dual_osc_prescaler_bench.sv
module dual_osc_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rtc_pulse = 1'b0;
  logic       osc_sel = 1'b0;
  logic [2:0] scale = 3'd0;
  logic [1:0] grp_en = 2'b11;
  logic       tick;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  string cur_req = "R2";
  int tick_seen = 0;

  bit    exp_q[$];
  string req_q[$];

  // reference model state: enabled source pulses since reset
  int sys_cnt = 0;
  int rtc_cnt = 0;

  always #4 clk = ~clk;

  dual_osc_prescaler u_dual_osc_prescaler (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rtc_pulse_i (rtc_pulse),
    .osc_sel_i   (osc_sel),
    .scale_i     (scale),
    .grp_en_i    (grp_en),
    .tick_o      (tick)
  );

  function automatic int div_of(input bit rtc, input logic [2:0] c);
    int sys_tab[8] = '{2, 8, 32, 64, 128, 256, 1024, 4096};
    return rtc ? (1 << c) : sys_tab[c];
  endfunction

  // real-time pulse source, irregular gaps of 5 and 7 cycles
  initial begin
    int gap = 5;
    forever begin
      repeat (gap) @(negedge clk);
      rtc_pulse = 1'b1;
      @(negedge clk);
      rtc_pulse = 1'b0;
      gap = (gap == 5) ? 7 : 5;
    end
  end

  // driver side: predict the output for the cycle after each edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit e;
      if (!osc_sel)
        e = grp_en[0] && ((sys_cnt + 1) % div_of(1'b0, scale) == 0);
      else
        e = grp_en[1] && rtc_pulse && ((rtc_cnt + 1) % div_of(1'b1, scale) == 0);
      exp_q.push_back(e);
      req_q.push_back(cur_req);
      if (grp_en[0]) sys_cnt = sys_cnt + 1;
      if (grp_en[1] && rtc_pulse) rtc_cnt = rtc_cnt + 1;
    end
  end

  // monitor side
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      bit e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      vectors++;
      if (tick) tick_seen++;
      if (tick !== e) begin
        misses++;
        $display("FAIL %s: tick_o=%b expected %b at %0t", r, tick, e, $time);
      end
    end
  end

  task automatic run(input bit sel, input logic [2:0] c, input logic [1:0] en,
                     input int cycles, input string req);
    @(negedge clk);
    osc_sel = sel;
    scale   = c;
    grp_en  = en;
    cur_req = req;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic expect_ticks(input bit want_some, input string req);
    vectors++;
    if ((tick_seen > 0) != want_some) begin
      misses++;
      $display("FAIL %s: tick count=%0d expected %s", req, tick_seen,
               want_some ? "nonzero" : "zero");
    end
    tick_seen = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: output quiet in reset
    vectors++;
    if (tick !== 1'b0) begin
      misses++;
      $display("FAIL R1: tick_o=%b expected 0 in reset", tick);
    end
    rst_n = 1'b1;
    tick_seen = 0;

    // R2: every system clock ratio
    for (int c = 0; c < 8; c++) begin
      run(1'b0, 3'(c), 2'b11, 3 * div_of(1'b0, 3'(c)) + 5, "R2");
      expect_ticks(1'b1, "R2");
    end
    // R3: every real-time ratio
    for (int c = 0; c < 8; c++) begin
      run(1'b1, 3'(c), 2'b11, 6 * 3 * div_of(1'b1, 3'(c)) + 10, "R3");
      expect_ticks(1'b1, "R3");
    end
    // R4: system source disabled, then resumed mid-count
    run(1'b0, 3'd3, 2'b11, 40, "R4");
    run(1'b0, 3'd3, 2'b10, 300, "R4");
    tick_seen = 0;
    run(1'b0, 3'd3, 2'b10, 200, "R4");
    expect_ticks(1'b0, "R4");
    run(1'b0, 3'd3, 2'b11, 200, "R4");
    // R5: real-time source disabled, then resumed
    run(1'b1, 3'd2, 2'b11, 50, "R5");
    run(1'b1, 3'd2, 2'b01, 10, "R5");
    tick_seen = 0;
    run(1'b1, 3'd2, 2'b01, 200, "R5");
    expect_ticks(1'b0, "R5");
    run(1'b1, 3'd2, 2'b11, 200, "R5");
    // R6: unselected enable is irrelevant
    run(1'b0, 3'd1, 2'b01, 100, "R6");
    expect_ticks(1'b1, "R6");
    run(1'b1, 3'd1, 2'b10, 100, "R6");
    expect_ticks(1'b1, "R6");
    // R7: code and source changes on a running chain
    run(1'b0, 3'd4, 2'b11, 77, "R7");
    run(1'b0, 3'd2, 2'b11, 45, "R7");
    run(1'b1, 3'd3, 2'b11, 90, "R7");
    run(1'b0, 3'd0, 2'b11, 9, "R7");
    run(1'b1, 3'd0, 2'b11, 60, "R7");
    expect_ticks(1'b1, "R7");
    // R8: fastest ratios, one-cycle width covered by the per-cycle compare
    run(1'b0, 3'd0, 2'b11, 30, "R8");
    run(1'b1, 3'd0, 2'b11, 30, "R8");
    expect_ticks(1'b1, "R8");
    // R1: reset mid-run clears chains
    @(negedge clk);
    rst_n = 1'b0;
    sys_cnt = 0;
    rtc_cnt = 0;
    @(negedge clk);
    vectors++;
    if (tick !== 1'b0) begin
      misses++;
      $display("FAIL R1: tick_o=%b expected 0 in reset", tick);
    end
    osc_sel = 1'b0;
    scale = 3'd2;
    cur_req = "R1";
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    finish_run();
  end

  initial begin
    #1_200_000;
    misses++;
    $display("FAIL watchdog: run incomplete, expected finish");
    finish_run();
  end
endmodule